// File: doc/BRIEF.md
# Pipelined CORDIC Complex Rotator

This block multiplies a complex fixed-point sample by e^(−jθ), which is the twiddle-factor product inside an FFT butterfly. It uses circular-mode CORDIC micro-rotations, so no hardware multiplier is needed. The angle arrives as a signed 16-bit word. The most negative code stands for −π, and one code step is π/32768. Angles beyond ±π/2 are first folded into the range where the iterations converge. After folding, twelve shift-and-add stages rotate the vector. A final stage removes the accumulated CORDIC gain of about 1.64676 with a fixed sum of shifted copies. It then rounds away the guard bits and saturates the result back to 16 bits.

The pipeline has one register per micro-rotation. A new sample can enter on every clock, because throughput matters more than latency at this point in the design. A valid bit travels alongside each sample. Each pipeline register loads only when its valid bit is set, so a result that has already left the pipeline stays on the outputs until the next one arrives.

Top module: `cordic_rotator`

## Requirements
- R1: For a sample accepted with real part Re, imaginary part Im and angle code A, where θ = A·π/32768, the result is outRe ≈ Re·cosθ + Im·sinθ and outIm ≈ Im·cosθ − Re·sinθ, within 40 LSB of the exact value after that value is rounded and clamped.
- R2: The angle code is read as two's complement. Code −32768 means −π and code 32767 means just below +π. Both give a result close to the negated input.
- R3: Angles whose two top code bits differ (|θ| ≥ π/2) are folded before the first micro-rotation, and they meet the same accuracy as R1.
- R4: The CORDIC gain is compensated. At angle code 0 the output matches the input within the R1 tolerance.
- R5: outValid rises exactly 14 clock cycles after the edge that samples inValid high. This is one cycle for folding, twelve for the micro-rotations and one for gain compensation with rounding.
- R6: Samples may be presented on consecutive cycles. Each one produces its own result, and the results come out in input order.
- R7: Outputs saturate symmetrically to +32767 and −32767. The code −32768 never appears on outRe or outIm while outValid is high.
- R8: While rst is high, and on the first cycle after it, outValid is 0. After reset, outRe and outIm are 0.
- R9: A cycle with inValid low produces no result. On every cycle with outValid low, outRe and outIm keep the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample strobe |
| inRe | input | 16 | Real part of the input sample, signed |
| inIm | input | 16 | Imaginary part of the input sample, signed |
| inAngle | input | 16 | Rotation angle, signed, π/32768 per code |
| outValid | output | 1 | Result strobe |
| outRe | output | 16 | Real part of the rotated sample, signed |
| outIm | output | 16 | Imaginary part of the rotated sample, signed |

## Verification
The bound checker watches the timing and framing rules on every cycle. These are the fixed 14-cycle gap between input and output strobes, a quiet outValid across reset, the absence of the code −32768 on valid results, and output values held still between results. Numerical correctness can only be shown by the bench scenarios. They compare each result with a trigonometric reference across all four quadrants, folded angles at and near ±π, zero angle, saturating inputs, dense bursts and sparse inputs with gaps, and they also check that the results come out in order.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;
  // sample and angle widths
  localparam int DATA_W  = 16;
  localparam int ANG_W   = 16;
  // micro-rotation count, fixed by the error budget
  localparam int STAGES  = 12;
  // extra fraction bits carried through the pipeline
  localparam int GUARD   = 2;
  // x/y need two integer bits of headroom: sqrt(2) input growth times gain 1.647
  localparam int XY_W    = DATA_W + 2 + GUARD;
  localparam int Z_W     = ANG_W + GUARD;
  localparam int CW      = XY_W + 1;
  // fold register + stages + compensation register
  localparam int LATENCY = STAGES + 2;

  typedef struct packed {
    logic [LATENCY-1:0] load;   // per-register load enables, index 0 = fold register
  } pipeStrobe_t;

  // atan(2^-idx) expressed in units of pi / 2^(Z_W-1)
  function automatic logic signed [Z_W-1:0] atanConst(input int idx);
    longint base;   // units of pi / 2^17
    case (idx)
      0:  base = 32768;
      1:  base = 19344;
      2:  base = 10221;
      3:  base = 5188;
      4:  base = 2604;
      5:  base = 1303;
      6:  base = 652;
      7:  base = 326;
      8:  base = 163;
      9:  base = 81;
      10: base = 41;
      11: base = 20;
      default: base = longint'(41722) >>> idx;
    endcase
    return Z_W'((base * (longint'(1) << (Z_W - 1))) / longint'(131072));
  endfunction

  // multiply by 1/K ~ 0.607253 as 2^-1 + 2^-3 - 2^-6 - 2^-9 - 2^-12 + 2^-14
  function automatic logic signed [CW-1:0] gainComp(input logic signed [CW-1:0] v);
    return (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9) - (v >>> 12) + (v >>> 14);
  endfunction

  // drop the guard bits with round-half-up and clamp to +/-(2^(DATA_W-1)-1)
  function automatic logic signed [DATA_W-1:0] roundSat(input logic signed [CW-1:0] v);
    logic signed [CW-1:0] r;
    logic signed [CW-1:0] posLim;
    logic signed [CW-1:0] negLim;
    posLim = CW'((longint'(1) << (DATA_W - 1)) - 1);
    negLim = -posLim;
    r = (v + CW'(longint'(1) << (GUARD - 1))) >>> GUARD;
    if (r > posLim)      return posLim[DATA_W-1:0];
    else if (r < negLim) return negLim[DATA_W-1:0];
    else                 return r[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/cordic_rot_ctrl.sv
module cordic_rot_ctrl
  import cordic_rot_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output pipeStrobe_t strobe,
  output logic        outValid
);
  logic [LATENCY-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[LATENCY-2:0], inValid};
  end

  // register k loads when the sample bound for it is valid
  assign strobe.load = {validPipe[LATENCY-2:0], inValid};
  assign outValid    = validPipe[LATENCY-1];
endmodule

// File: rtl/cordic_rot_stage.sv
module cordic_rot_stage
  import cordic_rot_pkg::*;
#(
  parameter int                     SHIFT = 0,
  parameter logic signed [Z_W-1:0]  ANGLE = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic signed [XY_W-1:0] xIn,
  input  logic signed [XY_W-1:0] yIn,
  input  logic signed [Z_W-1:0]  zIn,
  output logic signed [XY_W-1:0] xOut,
  output logic signed [XY_W-1:0] yOut,
  output logic signed [Z_W-1:0]  zOut
);
  logic                   turnPos;
  logic signed [XY_W-1:0] xSh;
  logic signed [XY_W-1:0] ySh;

  // residual angle sign picks the direction; rotating by -z drives z to zero
  assign turnPos = ~zIn[Z_W-1];
  assign xSh     = xIn >>> SHIFT;
  assign ySh     = yIn >>> SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      xOut <= '0;
      yOut <= '0;
      zOut <= '0;
    end else if (en) begin
      if (turnPos) begin
        xOut <= xIn + ySh;
        yOut <= yIn - xSh;
        zOut <= zIn - ANGLE;
      end else begin
        xOut <= xIn - ySh;
        yOut <= yIn + xSh;
        zOut <= zIn + ANGLE;
      end
    end
  end
endmodule

// File: rtl/cordic_rot_datapath.sv
module cordic_rot_datapath
  import cordic_rot_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  pipeStrobe_t              strobe,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  input  logic signed [ANG_W-1:0]  inAngle,
  output logic signed [DATA_W-1:0] outRe,
  output logic signed [DATA_W-1:0] outIm
);
  logic signed [XY_W-1:0] xPipe [0:STAGES];
  logic signed [XY_W-1:0] yPipe [0:STAGES];
  logic signed [Z_W-1:0]  zPipe [0:STAGES];

  // pre-rotation: |theta| >= pi/2 -> negate vector, shift angle by pi
  logic                   needFold;
  logic signed [XY_W-1:0] reExt;
  logic signed [XY_W-1:0] imExt;
  logic signed [Z_W-1:0]  zStart;

  always_comb begin
    needFold = inAngle[ANG_W-1] ^ inAngle[ANG_W-2];
    reExt    = $signed({{(XY_W-DATA_W){inRe[DATA_W-1]}}, inRe}) <<< GUARD;
    imExt    = $signed({{(XY_W-DATA_W){inIm[DATA_W-1]}}, inIm}) <<< GUARD;
    // adding pi modulo 2*pi flips the top angle bit
    zStart   = $signed({inAngle[ANG_W-1] ^ needFold, inAngle[ANG_W-2:0], {GUARD{1'b0}}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xPipe[0] <= '0;
      yPipe[0] <= '0;
      zPipe[0] <= '0;
    end else if (strobe.load[0]) begin
      xPipe[0] <= needFold ? -reExt : reExt;
      yPipe[0] <= needFold ? -imExt : imExt;
      zPipe[0] <= zStart;
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    cordic_rot_stage #(
      .SHIFT (s),
      .ANGLE (atanConst(s))
    ) stage_i (
      .clk  (clk),
      .rst  (rst),
      .en   (strobe.load[s+1]),
      .xIn  (xPipe[s]),
      .yIn  (yPipe[s]),
      .zIn  (zPipe[s]),
      .xOut (xPipe[s+1]),
      .yOut (yPipe[s+1]),
      .zOut (zPipe[s+1])
    );
  end

  // gain removal, rounding and saturation share the last register
  logic signed [CW-1:0] xWide;
  logic signed [CW-1:0] yWide;
  logic signed [CW-1:0] xComp;
  logic signed [CW-1:0] yComp;

  always_comb begin
    xWide = CW'(xPipe[STAGES]);
    yWide = CW'(yPipe[STAGES]);
    xComp = gainComp(xWide);
    yComp = gainComp(yWide);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outRe <= '0;
      outIm <= '0;
    end else if (strobe.load[LATENCY-1]) begin
      outRe <= roundSat(xComp);
      outIm <= roundSat(yComp);
    end
  end
endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator
  import cordic_rot_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  input  logic signed [ANG_W-1:0]  inAngle,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outRe,
  output logic signed [DATA_W-1:0] outIm
);
  pipeStrobe_t strobe;

  cordic_rot_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  cordic_rot_datapath dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .inRe    (inRe),
    .inIm    (inIm),
    .inAngle (inAngle),
    .outRe   (outRe),
    .outIm   (outIm)
  );
endmodule

// File: rtl/cordic_rotator_chk.sv
module cordic_rotator_chk
  import cordic_rot_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic                     inValid,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outRe,
  input logic signed [DATA_W-1:0] outIm
);
  logic [LATENCY-1:0] seenIn;
  localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) seenIn <= '0;
    else     seenIn <= {seenIn[LATENCY-2:0], inValid};
  end

  // R5: result strobe follows the input strobe by the full pipeline depth
  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    outValid == seenIn[LATENCY-1]);

  // R8: no result strobe right after a reset cycle
  assert_quiet_reset_R8: assert property (@(posedge clk)
    rst |=> !outValid);

  // R7: symmetric saturation never emits the most negative code
  assert_no_min_code_R7: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outRe != MOST_NEG) && (outIm != MOST_NEG));

  // R9: outputs hold between results
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outRe) && $stable(outIm));
endmodule

bind cordic_rotator cordic_rotator_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outRe    (outRe),
  .outIm    (outIm)
);

// File: tb/cordic_rotator_tb_top.sv
module cordic_rotator_tb_top;
  localparam int  CLK_PERIOD = 10;
  localparam int  LAT        = 14;
  localparam int  TOL        = 40;
  localparam real PI         = 3.141592653589793;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [15:0] inRe = '0, inIm = '0, inAngle = '0;
  logic outValid;
  logic signed [15:0] outRe, outIm;

  cordic_rotator dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .inAngle(inAngle), .outValid(outValid), .outRe(outRe), .outIm(outIm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int re; int im; int t; string tag; } exp_t;
  exp_t sbq[$];
  int checks = 0;
  int errors = 0;
  bit haveLast = 0;
  int lastRe = 0, lastIm = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int roundClamp(input real v);
    int r;
    r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    if (r > 32767)  r = 32767;
    if (r < -32767) r = -32767;
    return r;
  endfunction

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // driver: present one sample and queue its expected result
  task automatic send(input int re, input int im, input int ang, input string tag);
    real th;
    exp_t e;
    @(negedge clk);
    inValid = 1'b1;
    inRe    = 16'(re);
    inIm    = 16'(im);
    inAngle = 16'(ang);
    th   = real'(ang) * PI / 32768.0;
    e.re = roundClamp(real'(re) * $cos(th) + real'(im) * $sin(th));
    e.im = roundClamp(real'(im) * $cos(th) - real'(re) * $sin(th));
    e.t  = cyc;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // monitor: compare results as they appear
  always @(negedge clk) begin
    if (!rst) begin
      if (outValid) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R9", "result without input", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(absi(int'(outRe) - e.re) <= TOL, e.tag, "real part", int'(outRe), e.re);
          check(absi(int'(outIm) - e.im) <= TOL, e.tag, "imag part", int'(outIm), e.im);
          check(cyc - e.t == LAT, "R5", "latency", cyc - e.t, LAT);
        end
        haveLast = 1;
        lastRe = int'(outRe);
        lastIm = int'(outIm);
      end else if (haveLast) begin
        check(int'(outRe) == lastRe && int'(outIm) == lastIm, "R9", "hold real",
              int'(outRe), lastRe);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    // R8: reset state
    repeat (5) begin
      @(negedge clk);
      check(outValid == 1'b0, "R8", "outValid in reset", int'(outValid), 0);
    end
    rst = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R8", "outValid idle after reset", int'(outValid), 0);
    end
    check(outRe == 0 && outIm == 0, "R8", "outputs after reset", int'(outRe), 0);

    // R4: zero angle returns the input
    send(1000, -2000, 0, "R4");
    send(-30000, 12345, 0, "R4");
    send(0, 0, 0, "R4");
    idle(LAT + 2);

    // R1: angles inside +/- pi/2
    send(20000, 5000, 8192, "R1");
    send(-12000, 17000, -8192, "R1");
    send(15000, 15000, 5461, "R1");
    send(3000, -25000, 16000, "R1");
    send(-22000, -9000, -12000, "R1");
    idle(LAT + 2);

    // R3: folded angles
    send(18000, 7000, 24576, "R3");
    send(-9000, 21000, -24576, "R3");
    send(10000, -10000, 16384, "R3");
    send(25000, 1000, -16384, "R3");
    send(-14000, -14000, 30000, "R3");
    send(6000, 26000, -30000, "R3");
    idle(LAT + 2);

    // R2: angle code extremes
    send(12000, -7000, -32768, "R2");
    send(-20000, 4000, 32767, "R2");
    idle(LAT + 2);

    // R7: saturating results
    send(32767, 32767, 8192, "R7");
    send(-32768, -32768, 8192, "R7");
    send(-32768, 0, 0, "R7");
    idle(LAT + 2);

    // R6: dense burst
    for (int i = 0; i < 24; i++)
      send(((i * 1237) % 40000) - 20000, 19000 - ((i * 2903) % 38000),
           (i * 2731) - 32768, "R6");
    idle(3);

    // R9: sparse inputs with gaps
    for (int i = 0; i < 6; i++) begin
      send(4000 * i - 11000, 9000 - 3000 * i, 5000 * i - 15000, "R9");
      idle(i + 1);
    end
    idle(LAT + 4);

    check(sbq.size() == 0, "R6", "results outstanding", sbq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule